// File: doc/BRIEF.md
# Serial Boot Configuration Loader

This block fetches the processor's fundamental operating modes once, right after reset, from an external serial source such as a small ROM or a little glue logic. It divides the system clock to make a slow shift clock, presents that clock on a pin, and samples one data bit per slow period. It counts the bit positions and collects the configuration fields that sit at fixed positions in the stream.

When the last bit has been taken, the block decodes the collected fields into named configuration outputs and pulses a done flag. Reserved bits that are set and reserved code values both raise a sticky error flag. The decoded outputs stay fixed until the next reset, and the shift clock stays low.

The divider ratio (`DIV`, default 256) and the stream length in bits (`STREAM_LEN`, default 256, at least 27) are parameters.

Top module: `mode_boot_loader`

## Requirements
- R1: While loading, `mode_clk_o` repeats with a period of `DIV` system clocks. It is low for the first `DIV/2` clocks of each period and high for the rest. While idle it is low.
- R2: Bit k of the stream is sampled on the system clock edge at which `mode_clk_o` rises in slow period k, starting with bit 0 in the first period after reset release. After `STREAM_LEN*DIV` clock edges, `done_o` pulses high for exactly one cycle and `busy_o` goes low.
- R3: `pattern_o` is stream bits 1..4, with bit 4 as the MSB. A code above 8 sets `err_o`.
- R4: `clk_mult_o` is the code in bits 5..7 (bit 7 MSB) plus 2, which gives 2 to 8. Code 7 is reserved: it gives `clk_mult_o`=0 and sets `err_o`.
- R5: `big_endian_o` equals bit 8 and `bus32_o` equals bit 12. `timer_irq_en_o` is the inverse of bit 11, and `fast_mult_en_o` is the inverse of bit 19.
- R6: `wr_mode_o` is {bit10, bit9}. The value 2'b01 is reserved and sets `err_o`. The other values are 00 legacy, 10 pipelined and 11 re-issue.
- R7: `drive_pct_o` decodes {bit14, bit13} as follows: 10 gives 100, 11 gives 83, 00 gives 67 and 01 gives 50.
- R8: `wr_delay_o` is bits 15..17, with bit 17 as the MSB (0 to 7 cycles).
- R9: `cfg_id_o[1]` is bit 25 and `cfg_id_o[0]` is bit 26.
- R10: A 1 on a reserved bit sets `err_o`. The reserved bits are bit 0, bit 18, bits 20..24, and every bit from 27 to `STREAM_LEN-1`.
- R11: After reset every output is 0 except `busy_o`, which is 1. After `done_o`, the decoded outputs and `err_o` hold their values until the next reset, whatever `mode_data_i` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset; loading starts on release |
| mode_data_i | input | 1 | Serial configuration data |
| mode_clk_o | output | 1 | Slow shift clock to the source |
| busy_o | output | 1 | Loading in progress |
| done_o | output | 1 | One-cycle pulse after the final bit |
| err_o | output | 1 | Sticky reserved-bit or reserved-code error |
| pattern_o | output | 4 | Transmit data pattern code |
| clk_mult_o | output | 4 | Pipeline clock multiplier (0 if reserved) |
| big_endian_o | output | 1 | 1 selects big endian |
| wr_mode_o | output | 2 | Non-block write mode code |
| timer_irq_en_o | output | 1 | Timer interrupt enable |
| bus32_o | output | 1 | 1 selects the 32-bit system bus |
| drive_pct_o | output | 7 | Output driver strength in percent |
| wr_delay_o | output | 3 | Write address-to-data delay in cycles |
| fast_mult_en_o | output | 1 | Fast multiply enable |
| cfg_id_o | output | 2 | Configuration identifier |

## Verification
If the divider or bit counter slips, it shows straight away in the shape of `mode_clk_o`, and at the end it shows as `done_o` arriving on the wrong edge. Each slip moves the done pulse by `DIV` cycles or by one cycle. If the capture position is off by one, every decoded field shifts together. This is visible on the done edge as a wrong value in several fields at once, and it often also sets the error flag through a reserved bit. If the hold logic is lost, the outputs drift after done while the data pin is toggled.

// File: rtl/mode_boot_pkg.sv
package mode_boot_pkg;
  localparam int FIELD_BITS = 27;
  // reserved bit positions inside the decoded field range: 0, 18, 20..24
  localparam logic [FIELD_BITS-1:0] RSV_MASK = 27'h1F40001;

  localparam int PAT_LSB   = 1;
  localparam int RAT_LSB   = 5;
  localparam int END_BIT   = 8;
  localparam int WM_LSB    = 9;
  localparam int TMR_BIT   = 11;
  localparam int BUS_BIT   = 12;
  localparam int DRV_LSB   = 13;
  localparam int DLY_LSB   = 15;
  localparam int FM_BIT    = 19;
  localparam int ID_HI_BIT = 25;
  localparam int ID_LO_BIT = 26;

  localparam logic [3:0] PAT_MAX = 4'd8;

  typedef enum logic [1:0] {
    WM_LEGACY  = 2'b00,
    WM_RSVD    = 2'b01,
    WM_PIPE    = 2'b10,
    WM_REISSUE = 2'b11
  } wr_mode_e;

  typedef struct packed {
    logic [3:0] pattern;
    logic [3:0] clk_mult;
    logic       big_endian;
    wr_mode_e   wr_mode;
    logic       timer_irq_en;
    logic       bus32;
    logic [6:0] drive_pct;
    logic [2:0] wr_delay;
    logic       fast_mult_en;
    logic [1:0] cfg_id;
  } mode_cfg_t;
endpackage

// File: rtl/mode_clk_gen.sv
module mode_clk_gen #(
  parameter int DIV        = 256,
  parameter int STREAM_LEN = 256
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  output logic                          busy_o,
  output logic                          mode_clk_o,
  output logic                          sample_o,
  output logic [$clog2(STREAM_LEN)-1:0] bit_idx_o,
  output logic                          finish_o
);
  localparam int CW = $clog2(DIV);
  localparam int IW = $clog2(STREAM_LEN);
  localparam logic [CW-1:0] CNT_LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] CNT_MID  = CW'(DIV / 2);
  localparam logic [IW-1:0] IDX_LAST = IW'(STREAM_LEN - 1);

  logic [CW-1:0] cnt_q;
  logic [IW-1:0] idx_q;
  logic          busy_q;

  assign busy_o     = busy_q;
  assign bit_idx_o  = idx_q;
  assign mode_clk_o = busy_q && (cnt_q >= CNT_MID);
  assign sample_o   = busy_q && (cnt_q == CNT_MID);
  assign finish_o   = busy_q && (cnt_q == CNT_LAST) && (idx_q == IDX_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      idx_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == CNT_LAST) begin
        cnt_q <= '0;
        if (idx_q == IDX_LAST) busy_q <= 1'b0;
        else                   idx_q  <= idx_q + 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  p_idx_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (bit_idx_o <= IDX_LAST));
  p_finish_once_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    finish_o |=> (!busy_o && !finish_o));
  p_sample_in_high_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |=> mode_clk_o);
endmodule

// File: rtl/mode_capture.sv
module mode_capture
  import mode_boot_pkg::*;
#(
  parameter int STREAM_LEN = 256
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          sample_i,
  input  logic                          data_i,
  input  logic [$clog2(STREAM_LEN)-1:0] bit_idx_i,
  output logic [FIELD_BITS-1:0]         raw_o,
  output logic                          rsv_hit_o
);
  localparam int IW = $clog2(STREAM_LEN);
  localparam logic [IW-1:0] FIELD_END = IW'(FIELD_BITS);

  logic in_field;
  logic rsv_pos;

  assign in_field  = bit_idx_i < FIELD_END;
  assign rsv_pos   = in_field ? RSV_MASK[bit_idx_i[4:0]] : 1'b1;
  assign rsv_hit_o = sample_i && data_i && rsv_pos;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_o <= '0;
    end else if (sample_i && in_field) begin
      raw_o[bit_idx_i[4:0]] <= data_i;
    end
  end

  p_raw_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_i |=> $stable(raw_o));
endmodule

// File: rtl/mode_decode.sv
module mode_decode
  import mode_boot_pkg::*;
(
  input  logic [FIELD_BITS-1:0] raw_i,
  output mode_cfg_t             cfg_o,
  output logic                  code_bad_o
);
  logic [3:0] pat;
  logic [2:0] rat;
  logic [1:0] wm;
  logic [1:0] drv;

  assign pat = raw_i[PAT_LSB +: 4];
  assign rat = raw_i[RAT_LSB +: 3];
  assign wm  = raw_i[WM_LSB +: 2];
  assign drv = raw_i[DRV_LSB +: 2];

  always_comb begin
    cfg_o.pattern      = pat;
    cfg_o.clk_mult     = (rat == 3'd7) ? 4'd0 : ({1'b0, rat} + 4'd2);
    cfg_o.big_endian   = raw_i[END_BIT];
    cfg_o.wr_mode      = wr_mode_e'(wm);
    cfg_o.timer_irq_en = !raw_i[TMR_BIT];
    cfg_o.bus32        = raw_i[BUS_BIT];
    unique case (drv)
      2'b10:   cfg_o.drive_pct = 7'd100;
      2'b11:   cfg_o.drive_pct = 7'd83;
      2'b00:   cfg_o.drive_pct = 7'd67;
      default: cfg_o.drive_pct = 7'd50;
    endcase
    cfg_o.wr_delay     = raw_i[DLY_LSB +: 3];
    cfg_o.fast_mult_en = !raw_i[FM_BIT];
    cfg_o.cfg_id       = {raw_i[ID_HI_BIT], raw_i[ID_LO_BIT]};
  end

  assign code_bad_o = (pat > PAT_MAX) || (rat == 3'd7) || (wm == WM_RSVD);
endmodule

// File: rtl/mode_boot_loader.sv
module mode_boot_loader
  import mode_boot_pkg::*;
#(
  parameter int DIV        = 256,
  parameter int STREAM_LEN = 256
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mode_data_i,
  output logic       mode_clk_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       err_o,
  output logic [3:0] pattern_o,
  output logic [3:0] clk_mult_o,
  output logic       big_endian_o,
  output logic [1:0] wr_mode_o,
  output logic       timer_irq_en_o,
  output logic       bus32_o,
  output logic [6:0] drive_pct_o,
  output logic [2:0] wr_delay_o,
  output logic       fast_mult_en_o,
  output logic [1:0] cfg_id_o
);
  localparam int IW = $clog2(STREAM_LEN);

  logic                  sample;
  logic                  finish;
  logic [IW-1:0]         bit_idx;
  logic [FIELD_BITS-1:0] raw;
  logic                  rsv_hit;
  logic                  code_bad;
  mode_cfg_t             cfg_d, cfg_q;
  logic                  done_q, err_q;

  mode_clk_gen #(.DIV(DIV), .STREAM_LEN(STREAM_LEN)) u_clk (
    .clk_i, .rst_ni, .busy_o, .mode_clk_o,
    .sample_o(sample), .bit_idx_o(bit_idx), .finish_o(finish)
  );

  mode_capture #(.STREAM_LEN(STREAM_LEN)) u_cap (
    .clk_i, .rst_ni, .sample_i(sample), .data_i(mode_data_i),
    .bit_idx_i(bit_idx), .raw_o(raw), .rsv_hit_o(rsv_hit)
  );

  mode_decode u_dec (.raw_i(raw), .cfg_o(cfg_d), .code_bad_o(code_bad));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= finish;
      if (finish) cfg_q <= cfg_d;
      if (rsv_hit || (finish && code_bad)) err_q <= 1'b1;
    end
  end

  assign done_o         = done_q;
  assign err_o          = err_q;
  assign pattern_o      = cfg_q.pattern;
  assign clk_mult_o     = cfg_q.clk_mult;
  assign big_endian_o   = cfg_q.big_endian;
  assign wr_mode_o      = cfg_q.wr_mode;
  assign timer_irq_en_o = cfg_q.timer_irq_en;
  assign bus32_o        = cfg_q.bus32;
  assign drive_pct_o    = cfg_q.drive_pct;
  assign wr_delay_o     = cfg_q.wr_delay;
  assign fast_mult_en_o = cfg_q.fast_mult_en;
  assign cfg_id_o       = cfg_q.cfg_id;

  p_clk_low_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mode_clk_o);
  p_done_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_after_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  p_mult_legal_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (clk_mult_o == 4'd0 || (clk_mult_o >= 4'd2 && clk_mult_o <= 4'd8)));
  p_drive_legal_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (drive_pct_o == 7'd100 || drive_pct_o == 7'd83 ||
                drive_pct_o == 7'd67  || drive_pct_o == 7'd50));
  p_err_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  p_cfg_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !done_o) |=> ($stable(cfg_q) && !mode_clk_o));
endmodule

// File: tb/mode_boot_loader_tb.sv
module mode_boot_loader_tb_top;
  localparam int DIV = 8;
  localparam int LEN = 40;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic mode_data_i = 1'b0;
  logic mode_clk_o, busy_o, done_o, err_o;
  logic [3:0] pattern_o, clk_mult_o;
  logic big_endian_o, timer_irq_en_o, bus32_o, fast_mult_en_o;
  logic [1:0] wr_mode_o, cfg_id_o;
  logic [6:0] drive_pct_o;
  logic [2:0] wr_delay_o;

  int checks = 0;
  int failures = 0;
  int done_cycle;
  int clk_bad;

  always #2 clk_i = ~clk_i;

  mode_boot_loader #(.DIV(DIV), .STREAM_LEN(LEN)) dut_i (
    .clk_i, .rst_ni, .mode_data_i, .mode_clk_o, .busy_o, .done_o, .err_o,
    .pattern_o, .clk_mult_o, .big_endian_o, .wr_mode_o, .timer_irq_en_o,
    .bus32_o, .drive_pct_o, .wr_delay_o, .fast_mult_en_o, .cfg_id_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [LEN-1:0] mk(input logic [3:0] pat, input logic [2:0] rat,
      input logic endi, input logic [1:0] wm, input logic tmr_dis, input logic b32,
      input logic [1:0] drv, input logic [2:0] dly, input logic fm_dis, input logic [1:0] id);
    logic [LEN-1:0] s = '0;
    s[4:1] = pat; s[7:5] = rat; s[8] = endi; s[10:9] = wm; s[11] = tmr_dis;
    s[12] = b32; s[14:13] = drv; s[17:15] = dly; s[19] = fm_dis;
    s[25] = id[1]; s[26] = id[0];
    return s;
  endfunction

  function automatic int drv_pct(input logic [1:0] c);
    case (c)
      2'b10: return 100;
      2'b11: return 83;
      2'b00: return 67;
      default: return 50;
    endcase
  endfunction

  // reset, then serve the stream: bit k presented from the falling edge that opens period k
  task automatic run_load(input logic [LEN-1:0] s);
    int idx = 0;
    int n = 0;
    logic prev = 1'b0;
    rst_ni = 1'b0;
    mode_data_i = s[0];
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    done_cycle = -1;
    clk_bad = 0;
    while (n < LEN*DIV + 20) begin
      @(negedge clk_i);
      n++;
      if (done_o) begin done_cycle = n; break; end
      if (mode_clk_o != ((n % DIV) >= DIV/2)) clk_bad++;
      if (prev && !mode_clk_o && idx < LEN-1) idx++;
      mode_data_i = s[idx];
      prev = mode_clk_o;
    end
  endtask

  task automatic check_cfg(input string tag, input logic [LEN-1:0] s, input bit exp_err);
    int mult = (s[7:5] == 3'd7) ? 0 : int'(s[7:5]) + 2;
    chk(done_cycle == LEN*DIV, {tag, " R2 done timing"}, done_cycle, LEN*DIV);
    chk(clk_bad == 0, {tag, " R1 shift clock shape"}, clk_bad, 0);
    chk(pattern_o == s[4:1], {tag, " R3 pattern"}, pattern_o, s[4:1]);
    chk(clk_mult_o == mult, {tag, " R4 multiplier"}, clk_mult_o, mult);
    chk(big_endian_o == s[8] && bus32_o == s[12], {tag, " R5 endian/bus"},
        {big_endian_o, bus32_o}, {s[8], s[12]});
    chk(timer_irq_en_o == !s[11] && fast_mult_en_o == !s[19], {tag, " R5 timer/fastmul"},
        {timer_irq_en_o, fast_mult_en_o}, {!s[11], !s[19]});
    chk(wr_mode_o == s[10:9], {tag, " R6 write mode"}, wr_mode_o, s[10:9]);
    chk(drive_pct_o == drv_pct(s[14:13]), {tag, " R7 drive"}, drive_pct_o, drv_pct(s[14:13]));
    chk(wr_delay_o == s[17:15], {tag, " R8 delay"}, wr_delay_o, s[17:15]);
    chk(cfg_id_o == {s[25], s[26]}, {tag, " R9 config id"}, cfg_id_o, {s[25], s[26]});
    chk(err_o == exp_err, {tag, " R10 error flag"}, err_o, exp_err);
  endtask

  task automatic t_reset;
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    chk(!done_o && !err_o && !mode_clk_o && busy_o, "R11 reset flags",
        {busy_o, done_o, err_o, mode_clk_o}, 4'b1000);
    chk(pattern_o == 0 && clk_mult_o == 0 && drive_pct_o == 0 && cfg_id_o == 0 &&
        wr_delay_o == 0 && !timer_irq_en_o && !fast_mult_en_o, "R11 reset outputs",
        clk_mult_o, 0);
  endtask

  task automatic t_good(input string tag, input logic [LEN-1:0] s);
    run_load(s);
    check_cfg(tag, s, 1'b0);
  endtask

  task automatic t_bad(input string tag, input logic [LEN-1:0] s);
    run_load(s);
    chk(done_cycle == LEN*DIV, {tag, " R2 done timing"}, done_cycle, LEN*DIV);
    chk(err_o == 1'b1, {tag, " error set"}, err_o, 1);
  endtask

  task automatic t_hold(input logic [LEN-1:0] s, input bit exp_err);
    run_load(s);
    for (int i = 0; i < 5*DIV; i++) begin
      mode_data_i = ~mode_data_i;
      @(negedge clk_i);
      if (mode_clk_o || done_o || busy_o) clk_bad++;
    end
    chk(clk_bad == 0, "R11 idle after done", clk_bad, 0);
    check_cfg("R11 hold", s, exp_err);
  endtask

  initial begin
    logic [LEN-1:0] s;
    t_reset();
    t_good("A", mk(4'd5, 3'd3, 1'b1, 2'b10, 1'b1, 1'b1, 2'b11, 3'd6, 1'b0, 2'b10));
    t_good("B", mk(4'd8, 3'd6, 1'b0, 2'b11, 1'b0, 1'b0, 2'b01, 3'd7, 1'b1, 2'b01));
    t_good("C", mk(4'd0, 3'd0, 1'b0, 2'b00, 1'b0, 1'b0, 2'b00, 3'd0, 1'b0, 2'b00));
    t_good("D", mk(4'd1, 3'd4, 1'b1, 2'b00, 1'b0, 1'b1, 2'b10, 3'd1, 1'b0, 2'b11));
    t_bad("R3 pattern 9", mk(4'd9, 3'd0, 1'b0, 2'b00, 1'b0, 1'b0, 2'b10, 3'd0, 1'b0, 2'b00));
    s = mk(4'd2, 3'd7, 1'b0, 2'b00, 1'b0, 1'b0, 2'b10, 3'd0, 1'b0, 2'b00);
    run_load(s);
    check_cfg("R4 ratio 7", s, 1'b1);
    t_bad("R6 write mode 01", mk(4'd2, 3'd1, 1'b0, 2'b01, 1'b0, 1'b0, 2'b10, 3'd0, 1'b0, 2'b00));
    s = mk(4'd3, 3'd2, 1'b0, 2'b10, 1'b0, 1'b0, 2'b10, 3'd2, 1'b0, 2'b00);
    s[0] = 1'b1;  t_bad("R10 bit 0", s);  s[0] = 1'b0;
    s[18] = 1'b1; t_bad("R10 bit 18", s); s[18] = 1'b0;
    s[22] = 1'b1; t_bad("R10 bit 22", s); s[22] = 1'b0;
    s[LEN-1] = 1'b1;
    run_load(s);
    check_cfg("R10 last bit", s, 1'b1);
    s[LEN-1] = 1'b0;
    t_hold(mk(4'd6, 3'd5, 1'b1, 2'b11, 1'b1, 1'b0, 2'b00, 3'd4, 1'b1, 2'b10), 1'b0);
    t_hold(mk(4'd12, 3'd5, 1'b1, 2'b11, 1'b1, 1'b0, 2'b00, 3'd4, 1'b1, 2'b10), 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule